// File: doc/BRIEF.md
# SPI EEPROM Write Sequencer

This block sits on the host side of a serial EEPROM link and carries out one complete programming operation per request. A user presents a start address and a byte count on a valid/ready request port, then streams the data bytes through a second valid/ready port. The block turns this into the device's command sequence. First it sends a one-byte frame that arms the device's write latch. It then sends a frame that carries the program command, a two-byte address and the data. It then keeps issuing status-read frames until the device reports that its internal programming has finished.

The serial side runs in mode 0 with an active-low chip select. The serial clock is the system clock divided by an even ratio, and a minimum chip-select-high time is enforced before every frame. A bounded number of status polls protects against a device that never finishes: when the bound is used up, an error pulse replaces the done pulse. Splitting a request at page boundaries, reads and write-protect control are left to other logic.

Top module: `eewr_seq`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, req_ready is 1, and done and err are 0.
- R2: req_ready is 1 only while no operation is running. A request is taken on a clock where req_valid and req_ready are both 1. A request presented while an operation runs has no effect on the frames sent.
- R3: The first frame of an operation holds exactly one byte, 0x06, and chip select is then raised.
- R4: The second frame holds 0x02, then the address as 16 bits sent high byte first with bit 15 sent as 0, then exactly req_len data bytes in stream order. Chip select rises right after the last data byte.
- R5: Data bytes are taken on clocks where wdata_valid and wdata_ready are both 1, one byte per serial byte slot. While the stream is empty, chip select stays low and spi_sck stays idle.
- R6: Serial mode 0 is used. spi_sck is low whenever chip select is high or changes. spi_mosi changes only while spi_sck is low. Bits go out most significant first. Each spi_sck high phase lasts SCK_HALF system clocks.
- R7: Between any two frames, spi_cs_n stays high for at least CS_GAP_SCK*2*SCK_HALF system clocks.
- R8: Each status poll is its own two-byte frame: 0x05 and then a 0x00 filler byte. The busy flag is bit 0 of the byte received during the filler.
- R9: done pulses for one clock when a poll reads the busy flag as 0. The block then returns to idle with req_ready high.
- R10: If POLL_LIMIT polls in a row all read the busy flag as 1, err pulses for one clock instead of done, and the block returns to idle.
- R11: Any req_len from 1 to MAX_BYTES (64) is sent whole in one program frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Data byte count, 1 to MAX_BYTES |
| wdata_valid | input | 1 | Data byte offered |
| wdata_ready | output | 1 | Block waiting for the next data byte |
| wdata | input | 8 | Data byte |
| done | output | 1 | One-clock pulse: programming finished |
| err | output | 1 | One-clock pulse: poll limit reached while busy |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to device |
| spi_miso | input | 1 | Serial data from device |

## Verification
The bench builds the block with SCK_HALF=2, CS_GAP_SCK=2 and POLL_LIMIT=5. The short serial clock keeps even a full 64-byte frame to a few thousand clocks, so boundary lengths and several random operations fit in one run. The small poll limit lets a device model that stays busy for eight polls hit the timeout path. A device model in the bench holds the busy flag for a chosen number of polls, which sets the expected poll count for each operation. Random gaps in the data stream exercise the stall behaviour with chip select held low.

// File: rtl/eewr_pkg.sv
package eewr_pkg;

    localparam logic [7:0] OP_ARM  = 8'h06;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_STAT = 8'h05;
    localparam logic [7:0] FILLER  = 8'h00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_ARM,
        ST_PCMD,
        ST_ADRH,
        ST_ADRL,
        ST_DWAIT,
        ST_DATA,
        ST_PCMDS,
        ST_PREAD
    } seq_st_e;

endpackage

// File: rtl/eewr_byte_shift.sv
module eewr_byte_shift #(
    parameter int SCK_HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       done,
    output logic [7:0] rx
);

    localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
    localparam logic [CW-1:0] CNT_END = CW'(SCK_HALF - 1);

    typedef struct packed {
        logic          busy;
        logic          sck;
        logic          done;
        logic [2:0]    bitn;
        logic [CW-1:0] cnt;
        logic [7:0]    sh;
        logic [7:0]    rx;
    } shf_t;

    shf_t q, d;

    always_comb begin
        d = q;
        d.done = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.sck  = 1'b0;
                d.sh   = tx;
                d.cnt  = '0;
                d.bitn = '0;
            end
        end else if (q.cnt == CNT_END) begin
            d.cnt = '0;
            if (!q.sck) begin
                d.sck = 1'b1;
                d.rx  = {q.rx[6:0], miso};
            end else begin
                d.sck = 1'b0;
                if (q.bitn == 3'd7) begin
                    d.busy = 1'b0;
                    d.done = 1'b1;
                end else begin
                    d.bitn = q.bitn + 3'd1;
                    d.sh   = {q.sh[6:0], 1'b0};
                end
            end
        end else begin
            d.cnt = q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign sck  = q.sck;
    assign mosi = q.sh[7];
    assign busy = q.busy;
    assign done = q.done;
    assign rx   = q.rx;

    // R6: the controller never restarts a byte that is still shifting
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !q.busy);

    // R6: a finished byte leaves the clock parked low
    a_r6_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        q.done |-> (!q.sck && !q.busy));

endmodule

// File: rtl/eewr_ctrl.sv
module eewr_ctrl
    import eewr_pkg::*;
#(
    parameter int ADDR_W     = 15,
    parameter int MAX_BYTES  = 64,
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP_SCK = 2,
    parameter int POLL_LIMIT = 1000,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [7:0]        wdata,
    output logic              done,
    output logic              err,
    output logic              cs_n,
    output logic              x_start,
    output logic [7:0]        x_tx,
    input  logic              x_done,
    input  logic [7:0]        x_rx
);

    localparam int GAP_CYC = CS_GAP_SCK * 2 * SCK_HALF;
    localparam int GAP_W   = $clog2(GAP_CYC + 1);
    localparam int POLL_W  = $clog2(POLL_LIMIT + 1);
    localparam logic [GAP_W-1:0]  GAP_LOAD  = GAP_W'(GAP_CYC - 1);
    localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);

    typedef struct packed {
        seq_st_e           st;
        seq_st_e           nxt;
        logic              cs_n;
        logic              done;
        logic              err;
        logic [GAP_W-1:0]  gap;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  rem;
        logic [POLL_W-1:0] polls;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, nxt: ST_IDLE, cs_n: 1'b1, done: 1'b0, err: 1'b0,
        gap: '0, addr: '0, rem: '0, polls: '0
    };

    ctl_t q, d;
    logic [15:0] addr_word;

    assign addr_word = 16'(q.addr);

    always_comb begin
        d           = q;
        d.done      = 1'b0;
        d.err       = 1'b0;
        x_start     = 1'b0;
        x_tx        = FILLER;
        req_ready   = (q.st == ST_IDLE);
        wdata_ready = (q.st == ST_DWAIT);
        unique case (q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    d.addr  = req_addr;
                    d.rem   = req_len;
                    d.polls = '0;
                    d.st    = ST_GAP;
                    d.nxt   = ST_ARM;
                    d.gap   = GAP_LOAD;
                    d.cs_n  = 1'b1;
                end
            end
            ST_GAP: begin
                if (q.gap == '0) begin
                    d.st    = q.nxt;
                    d.cs_n  = 1'b0;
                    x_start = 1'b1;
                    if (q.nxt == ST_ARM) begin
                        x_tx = OP_ARM;
                    end else if (q.nxt == ST_PCMD) begin
                        x_tx = OP_PROG;
                    end else begin
                        x_tx = OP_STAT;
                    end
                end else begin
                    d.gap = q.gap - GAP_W'(1);
                end
            end
            ST_ARM: begin
                if (x_done) begin
                    d.st   = ST_GAP;
                    d.nxt  = ST_PCMD;
                    d.gap  = GAP_LOAD;
                    d.cs_n = 1'b1;
                end
            end
            ST_PCMD: begin
                if (x_done) begin
                    x_start = 1'b1;
                    x_tx    = {1'b0, addr_word[14:8]};
                    d.st    = ST_ADRH;
                end
            end
            ST_ADRH: begin
                if (x_done) begin
                    x_start = 1'b1;
                    x_tx    = addr_word[7:0];
                    d.st    = ST_ADRL;
                end
            end
            ST_ADRL: begin
                if (x_done) begin
                    d.st = ST_DWAIT;
                end
            end
            ST_DWAIT: begin
                if (wdata_valid) begin
                    x_start = 1'b1;
                    x_tx    = wdata;
                    d.st    = ST_DATA;
                end
            end
            ST_DATA: begin
                if (x_done) begin
                    d.rem = q.rem - LEN_W'(1);
                    if (q.rem == LEN_W'(1)) begin
                        d.st   = ST_GAP;
                        d.nxt  = ST_PCMDS;
                        d.gap  = GAP_LOAD;
                        d.cs_n = 1'b1;
                    end else begin
                        d.st = ST_DWAIT;
                    end
                end
            end
            ST_PCMDS: begin
                if (x_done) begin
                    x_start = 1'b1;
                    x_tx    = FILLER;
                    d.st    = ST_PREAD;
                end
            end
            ST_PREAD: begin
                if (x_done) begin
                    d.cs_n = 1'b1;
                    if (!x_rx[0]) begin
                        d.done = 1'b1;
                        d.st   = ST_IDLE;
                    end else if (q.polls == POLL_LAST) begin
                        d.err = 1'b1;
                        d.st  = ST_IDLE;
                    end else begin
                        d.polls = q.polls + POLL_W'(1);
                        d.st    = ST_GAP;
                        d.nxt   = ST_PCMDS;
                        d.gap   = GAP_LOAD;
                    end
                end
            end
            default: begin
                d = CTL_RST;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= CTL_RST;
        end else begin
            q <= d;
        end
    end

    assign done = q.done;
    assign err  = q.err;
    assign cs_n = q.cs_n;

    // R2: taking a request closes the request port on the next clock
    a_r2_accept_closes: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9 / R10: a finished operation reports exactly one outcome
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        !(q.done && q.err));

    // R9: completion is only reported with chip select released
    a_r9_done_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        (q.done || q.err) |-> q.cs_n);

    // R7: a chip-select release lasts more than one clock
    a_r7_gap_hold: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |=> q.cs_n);

    // R5: a data slot is only open while bytes remain
    a_r5_rem_left: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_DWAIT) |-> (q.rem != '0));

    // R10: the poll counter never passes its bound
    a_r10_polls_bound: assert property (@(posedge clk) disable iff (!rst_n)
        q.polls <= POLL_LAST);

endmodule

// File: rtl/eewr_seq.sv
module eewr_seq #(
    parameter int ADDR_W     = 15,
    parameter int MAX_BYTES  = 64,
    parameter int SCK_HALF   = 2,
    parameter int CS_GAP_SCK = 2,
    parameter int POLL_LIMIT = 1000,
    localparam int LEN_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              wdata_valid,
    output logic              wdata_ready,
    input  logic [7:0]        wdata,
    output logic              done,
    output logic              err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    logic       x_start;
    logic [7:0] x_tx;
    logic       x_done;
    logic       x_busy;
    logic [7:0] x_rx;

    eewr_ctrl #(
        .ADDR_W     (ADDR_W),
        .MAX_BYTES  (MAX_BYTES),
        .SCK_HALF   (SCK_HALF),
        .CS_GAP_SCK (CS_GAP_SCK),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .wdata_valid (wdata_valid),
        .wdata_ready (wdata_ready),
        .wdata       (wdata),
        .done        (done),
        .err         (err),
        .cs_n        (spi_cs_n),
        .x_start     (x_start),
        .x_tx        (x_tx),
        .x_done      (x_done),
        .x_rx        (x_rx)
    );

    eewr_byte_shift #(
        .SCK_HALF (SCK_HALF)
    ) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .start (x_start),
        .tx    (x_tx),
        .miso  (spi_miso),
        .sck   (spi_sck),
        .mosi  (spi_mosi),
        .busy  (x_busy),
        .done  (x_done),
        .rx    (x_rx)
    );

    // R6: chip select only moves while the serial clock is low
    a_r6_cs_edge_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_cs_n) |-> !spi_sck);

    // R6: no shifting while chip select is released
    a_r6_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !x_busy);

endmodule

// File: tb/eewr_seq_bench.sv
module eewr_seq_bench;

    localparam int ADDR_W     = 15;
    localparam int MAX_BYTES  = 64;
    localparam int SCK_HALF   = 2;
    localparam int CS_GAP_SCK = 2;
    localparam int POLL_LIMIT = 5;
    localparam int LEN_W      = $clog2(MAX_BYTES + 1);
    localparam int GAP_CYC    = CS_GAP_SCK * 2 * SCK_HALF;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              wdata_valid = 1'b0;
    logic              wdata_ready;
    logic [7:0]        wdata = '0;
    logic              done;
    logic              err;
    logic              spi_sck;
    logic              spi_cs_n;
    logic              spi_mosi;
    logic              spi_miso = 1'b0;

    eewr_seq #(
        .ADDR_W     (ADDR_W),
        .MAX_BYTES  (MAX_BYTES),
        .SCK_HALF   (SCK_HALF),
        .CS_GAP_SCK (CS_GAP_SCK),
        .POLL_LIMIT (POLL_LIMIT)
    ) u_eewr_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .wdata_valid (wdata_valid),
        .wdata_ready (wdata_ready),
        .wdata       (wdata),
        .done        (done),
        .err         (err),
        .spi_sck     (spi_sck),
        .spi_cs_n    (spi_cs_n),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso)
    );

    always #4 clk = ~clk;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    // ---------------- device model ----------------
    logic [7:0] fb [0:63][0:71];
    int         fl [0:63];
    int         nfr = 0;
    int         nb = 0;
    logic [7:0] sh = '0;
    bit         in_frame = 0;
    bit         wel = 0;
    bit         wip = 0;
    int         left = 0;
    int         busy_cfg = 0;

    function automatic logic [7:0] stat_byte();
        return {6'b0, wel, wip};
    endfunction

    always @(negedge spi_cs_n) begin
        nb = 0;
        in_frame = 1;
        spi_miso = 1'b0;
    end

    always @(posedge spi_sck) begin
        if (spi_cs_n == 1'b0) begin
            sh = {sh[6:0], spi_mosi};
            nb++;
            if ((nb % 8) == 0 && nfr < 64 && (nb / 8) <= 72) fb[nfr][nb/8-1] = sh;
        end
    end

    always @(negedge spi_sck) begin
        if (spi_cs_n == 1'b0 && nb >= 8 && nb < 16 && nfr < 64 && fb[nfr][0] == 8'h05)
            spi_miso = stat_byte()[15-nb];
    end

    always @(posedge spi_cs_n) begin
        if (in_frame && nfr < 64) begin
            in_frame = 0;
            fl[nfr] = nb / 8;
            if (fl[nfr] == 1 && fb[nfr][0] == 8'h06) wel = 1;
            if (fl[nfr] >= 1 && fb[nfr][0] == 8'h02 && wel) begin
                wel  = 0;
                left = busy_cfg;
                wip  = (busy_cfg != 0);
            end
            if (fl[nfr] >= 1 && fb[nfr][0] == 8'h05) begin
                if (left > 0) left--;
                wip = (left != 0);
            end
            nfr++;
        end
    end

    // ---------------- data stream driver ----------------
    logic [7:0] exp_d [0:63];
    int cur_len = 0;
    int wd_idx  = 0;
    bit wd_pend = 0;
    bit stall_en = 0;

    always @(negedge clk) begin
        if (wd_pend) wd_idx++;
        if (wd_idx < cur_len && (!stall_en || ($urandom % 3) != 0)) begin
            wdata_valid = 1'b1;
            wdata       = exp_d[wd_idx];
        end else begin
            wdata_valid = 1'b0;
        end
        wd_pend = wdata_valid && wdata_ready;
    end

    // ---------------- pin timing monitor ----------------
    int done_cnt = 0;
    int err_cnt  = 0;
    int r6_bad = 0;
    int r7_bad = 0;
    int hir = 0;
    int cshi = 0;
    bit pcs = 1, psck = 0, pmosi = 0, seen = 0;

    always @(negedge clk) begin
        cycles++;
        if (rst_n) begin
            if (done) done_cnt++;
            if (err) err_cnt++;
            if (spi_cs_n) begin
                if (spi_sck) r6_bad++;
                cshi++;
            end else begin
                if (pcs && seen && cshi < GAP_CYC) r7_bad++;
                if (pcs) seen = 1;
                cshi = 0;
                if (spi_sck && psck && spi_mosi != pmosi) r6_bad++;
                if (spi_sck) hir++;
                else begin
                    if (psck && hir != SCK_HALF) r6_bad++;
                    hir = 0;
                end
            end
            pcs = spi_cs_n; psck = spi_sck; pmosi = spi_mosi;
        end
    end

    // ---------------- operation runner ----------------
    task automatic run_op(input logic [ADDR_W-1:0] a, input int len, input int nbusy, input bit stall);
        int exp_polls;
        int mm;
        int waitc;
        bit timeout;
        timeout = (nbusy >= POLL_LIMIT);
        exp_polls = timeout ? POLL_LIMIT : nbusy + 1;
        @(posedge clk);
        for (int i = 0; i < 64; i++) exp_d[i] = 8'($urandom);
        nfr = 0; busy_cfg = nbusy; wd_idx = 0; cur_len = len; stall_en = stall;
        done_cnt = 0; err_cnt = 0; r6_bad = 0; r7_bad = 0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready while idle", int'(req_ready), 1);
        req_valid = 1'b1; req_addr = a; req_len = LEN_W'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(req_ready == 1'b0, "R2 ready dropped after accept", int'(req_ready), 0);
        repeat (40) @(negedge clk);
        req_valid = 1'b1; req_addr = ~a; req_len = LEN_W'(1);
        chk(req_ready == 1'b0, "R2 busy request ignored", int'(req_ready), 0);
        @(negedge clk);
        req_valid = 1'b0;
        waitc = 0;
        while (done_cnt + err_cnt == 0 && waitc < 30000) begin
            @(negedge clk);
            waitc++;
        end
        repeat (4) @(negedge clk);
        cur_len = 0;
        chk(nfr == 2 + exp_polls, "R8 frame count", nfr, 2 + exp_polls);
        chk(fl[0] == 1 && fb[0][0] == 8'h06, "R3 arm frame", int'(fb[0][0]), 8'h06);
        chk(fl[1] == 3 + len, "R11 program frame length", fl[1], 3 + len);
        chk(fb[1][0] == 8'h02, "R4 program opcode", int'(fb[1][0]), 8'h02);
        chk(fb[1][1] == {1'b0, a[14:8]}, "R4 address high byte", int'(fb[1][1]), int'({1'b0, a[14:8]}));
        chk(fb[1][2] == a[7:0], "R4 address low byte", int'(fb[1][2]), int'(a[7:0]));
        mm = 0;
        for (int i = 0; i < len; i++) if (fb[1][3+i] != exp_d[i]) mm++;
        chk(mm == 0, "R4 data byte mismatches", mm, 0);
        chk(wd_idx == len, "R5 bytes taken from stream", wd_idx, len);
        mm = 0;
        for (int p = 2; p < nfr && p < 64; p++)
            if (fl[p] != 2 || fb[p][0] != 8'h05 || fb[p][1] != 8'h00) mm++;
        chk(mm == 0, "R8 malformed poll frames", mm, 0);
        chk(r6_bad == 0, "R6 serial timing violations", r6_bad, 0);
        chk(r7_bad == 0, "R7 short deselect gaps", r7_bad, 0);
        if (timeout) begin
            chk(err_cnt == 1, "R10 err pulse count", err_cnt, 1);
            chk(done_cnt == 0, "R10 no done on timeout", done_cnt, 0);
            wip = 0; left = 0;
        end else begin
            chk(done_cnt == 1, "R9 done pulse count", done_cnt, 1);
            chk(err_cnt == 0, "R9 no err on success", err_cnt, 0);
        end
        chk(req_ready == 1'b1, "R9 idle after finish", int'(req_ready), 1);
    endtask

    initial begin
        int seed_init;
        seed_init = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1, "R1 cs_n at reset", int'(spi_cs_n), 1);
        chk(spi_sck == 1'b0, "R1 sck at reset", int'(spi_sck), 0);
        chk(req_ready == 1'b1, "R1 ready at reset", int'(req_ready), 1);
        chk(done == 1'b0 && err == 1'b0, "R1 done/err at reset", int'({done, err}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1'b1 && done == 1'b0, "R1 quiet after reset", int'(spi_cs_n), 1);
        run_op(15'h7FFF, 1, 0, 1'b0);
        run_op(15'h0040, 64, 2, 1'b1);
        run_op(15'h1234, 3, 8, 1'b0);
        run_op(15'h0100, MAX_BYTES, 4, 1'b0);
        for (int k = 0; k < 5; k++)
            run_op(ADDR_W'($urandom), 1 + int'($urandom % 64), int'($urandom % 4), 1'($urandom % 2));
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles >= 150000);
        fails++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule